// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. It derives a conversion clock from the system clock and, on each conversion-clock cycle, either holds the sampling and settling phase or resolves one bit of the code. It resolves the bits from the most significant down, using a single comparator bit returned by the analog side. Each conversion has a fixed length set by the resolution (8 or 10 bits) and by whether the sample-and-hold phase is used.

A conversion is launched by a software start request or, in trigger mode, by a falling edge on an external trigger pin once the request has armed the block. A later falling edge restarts the conversion. Five sequencing modes pick the order in which channels are driven on the mux-select output:

- single conversion of one channel;
- continuous conversion of one channel;
- one pass over a channel range;
- endless passes over a channel range;
- endless passes with a priority channel converted between every range channel.

Each result lands in that channel's own result register, which can be read through a read-address port. Each write is announced by a one-clock pulse. The block also drives the enable for the reference ladder.

Top module: `sar_sequencer`

## Requirements
- R1: `div_sel` sets the conversion-clock divisor from the system clock: 0→1, 1→2, 2→3, 3→4, 4→6, and 5, 6 or 7→12.
- R2: A conversion lasts L conversion-clock cycles. L is 49 (8-bit) or 59 (10-bit) with `hold_en`=0, and 28 (8-bit) or 33 (10-bit) with `hold_en`=1. `done` is seen L×divisor clocks after the edge that captures the start.
- R3: During the first L−N conversion-clock cycles (N = 8 or 10 bits) `sample` is 1 and `dac_code` is 0. Then `dac_code` carries the trial code. When idle, `sample` is 0 and `dac_code` is 0.
- R4: Bits are decided MSB first. A trial bit is kept when `cmp`=1, meaning the input is at or above `dac_code`. With an ideal comparator the result equals the input code. An 8-bit result is right-aligned in the 10-bit field, with bits 9:8 zero.
- R5: With `ext_mode`=0, a `go_set` pulse sets `run` and starts converting. A `go_set` while `run` is already 1 is ignored.
- R6: With `ext_mode`=1, `go_set` only sets `run`. A conversion starts on a falling edge of `trig_n` seen while `run` is already 1. Falling edges while `run` is 0 are ignored.
- R7: A falling edge of `trig_n` during a conversion in trigger mode restarts it, and the full length L follows.
- R8: Mode 0 (single) converts `chan_sel` once, then clears `run` and `busy`.
- R9: Mode 1 (continuous) converts `chan_sel` back-to-back, one result every L×divisor clocks.
- R10: Mode 2 (range once) converts channels 0 to `sweep_last` in ascending order, then clears `run`.
- R11: Mode 3 (range loop) converts 0 to `sweep_last`, then wraps to 0, until stopped.
- R12: Mode 4 (and codes 5 to 7) converts `chan_sel` before every range channel: `chan_sel`, 0, `chan_sel`, 1, …, wrapping after `sweep_last`.
- R13: Each result write raises `done` for exactly one clock, with `done_ch` and `done_data`. `rd_data` returns the stored result of channel `rd_ch`.
- R14: `go_clr` clears `run` and `busy` at the next edge and aborts any conversion. `ref_en` is 1 whenever `ref_keep` is 1 or a conversion is running, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_set | input | 1 | Start request pulse |
| go_clr | input | 1 | Stop request pulse |
| ext_mode | input | 1 | 1 = start on trigger edge |
| trig_n | input | 1 | External trigger, falling edge active |
| res10 | input | 1 | 1 = 10-bit, 0 = 8-bit |
| hold_en | input | 1 | 1 = sample-and-hold timing |
| ref_keep | input | 1 | Keep reference connected while idle |
| div_sel | input | 3 | Conversion-clock divisor select |
| mode | input | 3 | Sequencing mode |
| chan_sel | input | 5 | Selected or priority channel |
| sweep_last | input | 5 | Last channel of the range |
| rd_ch | input | 5 | Result read address |
| cmp | input | 1 | Comparator: input ≥ trial code |
| run | output | 1 | Start bit state |
| busy | output | 1 | Conversion in progress |
| sample | output | 1 | Sampling/settling phase |
| ref_en | output | 1 | Reference ladder enable |
| done | output | 1 | Result written pulse |
| mux_sel | output | 5 | Analog channel select |
| done_ch | output | 5 | Channel of the last result |
| dac_code | output | 10 | Trial code to the DAC |
| done_data | output | 10 | Value of the last result |
| rd_data | output | 10 | Result of channel `rd_ch` |

## Verification
A phase counter out by one moves `done` by a whole divisor period and shifts the fall of `sample`. Both show within one conversion, as a wrong cycle count at the ports. A bad bit index or keep decision gives a wrong `done_data` at the very next result, because the comparator model is exact. A wrong next-channel choice shows as an out-of-order `done_ch` within two or three conversions of a sweep. A lost arm or restart shows as `busy` staying low, or as a done time counted from the wrong edge.

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int NCH = 26,
  parameter int CW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_set,
  input  logic          go_clr,
  input  logic          ext_mode,
  input  logic          trig_n,
  input  logic          res10,
  input  logic          hold_en,
  input  logic          ref_keep,
  input  logic [2:0]    div_sel,
  input  logic [2:0]    mode,
  input  logic [CW-1:0] chan_sel,
  input  logic [CW-1:0] sweep_last,
  input  logic [CW-1:0] rd_ch,
  input  logic          cmp,
  output logic          run,
  output logic          busy,
  output logic          sample,
  output logic          ref_en,
  output logic          done,
  output logic [CW-1:0] mux_sel,
  output logic [CW-1:0] done_ch,
  output logic [9:0]    dac_code,
  output logic [9:0]    done_data,
  output logic [9:0]    rd_data
);
  localparam logic [2:0] M_ONE = 3'd0, M_REP = 3'd1, M_SWP = 3'd2, M_LOOP = 3'd3;

  logic [3:0]    dcnt, div_m1, bidx;
  logic [5:0]    cnt, len, first_dec;
  logic [9:0]    sar, result;
  logic [CW-1:0] ch, swp, nxt_ch, nxt_swp, init_ch;
  logic          alt, nxt_alt, stop, trig_q, tick, last, dec, fall, start;
  logic [9:0]    res_q [NCH];

  always_comb begin
    case (div_sel)
      3'd0:    div_m1 = 4'd0;
      3'd1:    div_m1 = 4'd1;
      3'd2:    div_m1 = 4'd2;
      3'd3:    div_m1 = 4'd3;
      3'd4:    div_m1 = 4'd5;
      default: div_m1 = 4'd11;
    endcase
  end

  assign len       = hold_en ? (res10 ? 6'd33 : 6'd28) : (res10 ? 6'd59 : 6'd49);
  assign first_dec = len - (res10 ? 6'd10 : 6'd8);
  assign dec       = busy && (cnt >= first_dec);
  assign bidx      = 4'(len - 6'd1 - cnt);
  assign tick      = busy && (dcnt == div_m1);
  assign last      = tick && (cnt == len - 6'd1);
  assign fall      = trig_q && !trig_n;
  assign start     = !go_clr && ((!ext_mode && go_set && !run) || (ext_mode && run && fall));
  assign init_ch   = (mode == M_SWP || mode == M_LOOP) ? '0 : chan_sel;
  assign result    = {sar[9:1], cmp};
  assign dac_code  = dec ? (sar | (10'd1 << bidx)) : 10'd0;
  assign sample    = busy && !dec;
  assign mux_sel   = ch;
  assign ref_en    = ref_keep || busy;
  assign rd_data   = (rd_ch < CW'(NCH)) ? res_q[rd_ch] : 10'd0;

  always_comb begin
    nxt_ch  = ch;
    nxt_swp = swp;
    nxt_alt = alt;
    stop    = 1'b0;
    case (mode)
      M_ONE:  stop = 1'b1;
      M_REP:  ;
      M_SWP:  if (ch == sweep_last) stop = 1'b1; else nxt_ch = ch + 1'b1;
      M_LOOP: nxt_ch = (ch == sweep_last) ? '0 : ch + 1'b1;
      default:
        if (!alt) begin
          nxt_ch  = swp;
          nxt_alt = 1'b1;
        end else begin
          nxt_swp = (swp == sweep_last) ? '0 : swp + 1'b1;
          nxt_ch  = chan_sel;
          nxt_alt = 1'b0;
        end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; busy <= 1'b0; done <= 1'b0; trig_q <= 1'b1;
      dcnt <= '0; cnt <= '0; sar <= '0; ch <= '0; swp <= '0; alt <= 1'b0;
      done_ch <= '0; done_data <= '0;
      for (int i = 0; i < NCH; i++) res_q[i] <= '0;
    end else begin
      trig_q <= trig_n;
      done   <= 1'b0;
      if (go_clr) begin
        run  <= 1'b0;
        busy <= 1'b0;
      end else if (start) begin
        run <= 1'b1; busy <= 1'b1;
        cnt <= '0; dcnt <= '0; sar <= '0;
        ch <= init_ch; swp <= '0; alt <= 1'b0;
      end else begin
        if (go_set && ext_mode) run <= 1'b1;
        if (busy) dcnt <= tick ? 4'd0 : dcnt + 4'd1;
        if (tick) begin
          if (dec) sar[bidx] <= cmp;
          if (last) begin
            done      <= 1'b1;
            done_ch   <= ch;
            done_data <= result;
            res_q[ch] <= result;
            cnt <= '0; sar <= '0;
            ch <= nxt_ch; swp <= nxt_swp; alt <= nxt_alt;
            if (stop) begin
              busy <= 1'b0;
              run  <= 1'b0;
            end
          end else begin
            cnt <= cnt + 6'd1;
          end
        end
      end
    end
  end
endmodule

module sar_sequencer_chk #(
  parameter int NCH = 26,
  parameter int CW  = $clog2(NCH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go_set,
  input logic          go_clr,
  input logic          res10,
  input logic          run,
  input logic          busy,
  input logic          sample,
  input logic          ref_en,
  input logic          done,
  input logic [CW-1:0] done_ch,
  input logic [9:0]    dac_code,
  input logic [9:0]    done_data
);
  assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_chan_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_ch < CW'(NCH));
  assert_clr_stops_R14: assert property (@(posedge clk) disable iff (!rst_n)
    go_clr |=> (!busy && !run));
  assert_ref_on_R14: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ref_en);
  assert_short_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res10) |-> done_data[9:8] == 2'b00);
  assert_armed_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(go_set) || $past(run)));
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sample && dac_code == 10'd0));
endmodule

bind sar_sequencer sar_sequencer_chk #(.NCH(NCH), .CW(CW)) u_chk (.*);

// File: tb/sar_sequencer_tb.sv
module sar_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 26;

  logic clk = 1'b0, rst_n = 1'b0;
  logic go_set = 0, go_clr = 0, ext_mode = 0, trig_n = 1, res10 = 1, hold_en = 0, ref_keep = 0;
  logic [2:0] div_sel = 0, mode = 0;
  logic [4:0] chan_sel = 0, sweep_last = 0, rd_ch = 0;
  logic cmp;
  logic run, busy, sample, ref_en, done;
  logic [4:0] mux_sel, done_ch;
  logic [9:0] dac_code, done_data, rd_data;
  logic [9:0] vin [NCH];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp = ((res10 ? vin[mux_sel] : {2'b00, vin[mux_sel][9:2]}) >= dac_code);

  sar_sequencer u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expv(input int c);
    return res10 ? int'(vin[c]) : int'(vin[c] >> 2);
  endfunction

  function automatic int lenof(input bit r, input bit h);
    return h ? (r ? 33 : 28) : (r ? 59 : 49);
  endfunction

  function automatic int divof(input int s);
    case (s)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 6;
      default: return 12;
    endcase
  endfunction

  task automatic pulse_go();
    @(negedge clk) go_set = 1;
    @(negedge clk) go_set = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) go_clr = 1;
    @(negedge clk) go_clr = 0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 20000);
    if (!done) chk("R13 done timeout", 0, 1);
  endtask

  task automatic t_reset();
    chk("R14 reset run", run, 0);
    chk("R14 reset busy", busy, 0);
    chk("R13 reset done", done, 0);
    chk("R14 reset ref_en", ref_en, 0);
    chk("R13 reset rd_data", rd_data, 0);
    ref_keep = 1;
    #1 chk("R14 ref_keep idle", ref_en, 1);
    ref_keep = 0;
  endtask

  task automatic t_single(input bit r, input bit h, input int ds, input int c);
    int n;
    res10 = r; hold_en = h; div_sel = 3'(ds); mode = 0; chan_sel = 5'(c);
    pulse_go();
    chk("R5 busy after start", busy, 1);
    chk("R14 ref_en while busy", ref_en, 1);
    wait_done(n);
    chk("R1 R2 conversion clocks", n, lenof(r, h) * divof(ds));
    chk("R4 result value", done_data, expv(c));
    chk("R13 done channel", done_ch, c);
    chk("R8 run cleared", run, 0);
    @(negedge clk);
    chk("R13 done one clock", done, 0);
    rd_ch = 5'(c);
    #1 chk("R13 stored result", rd_data, expv(c));
    if (!r) chk("R4 upper bits zero", int'(done_data[9:8]), 0);
  endtask

  task automatic t_phase();
    res10 = 1; hold_en = 1; div_sel = 0; mode = 0; chan_sel = 9;
    pulse_go();
    chk("R3 sample at start", sample, 1);
    repeat (22) @(negedge clk);
    chk("R3 sample last settle cycle", sample, 1);
    chk("R3 dac idle in sampling", dac_code, 0);
    @(negedge clk);
    chk("R3 sample ends", sample, 0);
    chk("R3 MSB trial code", dac_code, 512);
    pulse_go();
    chk("R5 go while running ignored", busy, 1);
    pulse_clr();
    chk("R14 clear stops", busy, 0);
  endtask

  task automatic t_repeat();
    int n;
    res10 = 1; hold_en = 1; div_sel = 1; mode = 1; chan_sel = 5;
    pulse_go();
    for (int k = 0; k < 3; k++) begin
      wait_done(n);
      if (k > 0) chk("R9 repeat period", n, 66);
      chk("R9 repeat channel", done_ch, 5);
      chk("R9 run held", run, 1);
    end
    repeat (5) @(negedge clk);
    pulse_clr();
    chk("R14 abort busy", busy, 0);
    chk("R14 abort run", run, 0);
    n = 0;
    repeat (200) begin
      @(negedge clk);
      if (done) n++;
    end
    chk("R14 no result after abort", n, 0);
  endtask

  task automatic t_sweep(input int md, input int pri, input int lastc, input int cnt_n);
    int n, exp_ch, sw;
    bit alt;
    res10 = 0; hold_en = 1; div_sel = 0; mode = 3'(md); chan_sel = 5'(pri); sweep_last = 5'(lastc);
    pulse_go();
    sw = 0; alt = 0;
    for (int k = 0; k < cnt_n; k++) begin
      wait_done(n);
      if (md == 4) begin
        exp_ch = alt ? sw : pri;
        if (alt) sw = (sw == lastc) ? 0 : sw + 1;
        alt = !alt;
        chk("R12 interleave channel", done_ch, exp_ch);
      end else begin
        exp_ch = (md == 3) ? k % (lastc + 1) : k;
        if (md == 3) chk("R11 loop channel", done_ch, exp_ch);
        else chk("R10 sweep channel", done_ch, exp_ch);
      end
      chk("R4 sweep value", done_data, expv(exp_ch));
    end
    if (md == 2) begin
      chk("R10 sweep ends run", run, 0);
      chk("R10 sweep ends busy", busy, 0);
    end else begin
      chk("R11 R12 still running", busy, 1);
      pulse_clr();
    end
  endtask

  task automatic t_ext();
    int n;
    ext_mode = 1; res10 = 0; hold_en = 1; div_sel = 0; mode = 0; chan_sel = 17;
    @(negedge clk) trig_n = 0;
    @(negedge clk) trig_n = 1;
    repeat (4) @(negedge clk);
    chk("R6 edge unarmed ignored", busy, 0);
    pulse_go();
    repeat (3) @(negedge clk);
    chk("R6 armed run", run, 1);
    chk("R6 armed not busy", busy, 0);
    @(negedge clk) trig_n = 0;
    @(negedge clk);
    chk("R6 edge starts", busy, 1);
    repeat (10) @(negedge clk);
    trig_n = 1;
    @(negedge clk) trig_n = 0;
    @(negedge clk);
    wait_done(n);
    chk("R7 restart full length", n, 28);
    chk("R6 ext result", done_data, expv(17));
    chk("R8 ext single clears run", run, 0);
    ext_mode = 0; trig_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) vin[i] = 10'((i * 397 + 113) % 1024);
    vin[3] = 10'h3FF; vin[20] = 10'h000; vin[9] = 10'h201;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_single(1, 0, 0, 3);
    t_single(0, 1, 2, 20);
    t_single(1, 1, 5, 11);
    t_single(0, 0, 4, 25);
    t_single(1, 1, 1, 0);
    t_single(0, 0, 3, 7);
    t_single(0, 1, 7, 14);
    t_phase();
    t_repeat();
    t_sweep(2, 0, 3, 4);
    t_sweep(3, 0, 2, 5);
    t_sweep(4, 7, 1, 6);
    t_ext();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule